// File: doc/BRIEF.md
# I2C Serial EEPROM Slave (2 KiB)

This block is an I2C slave that behaves as a 2048-byte serial EEPROM whose storage lives inside the chip. A bus master reaches it over SCL and SDA. SDA is open-drain: when `sda_oe` is 1, the block pulls the line low. Inputs are sampled with the system clock through a two-stage synchronizer, and an edge detector turns them into SCL edges and START/STOP events. A byte-level controller does the shifting, acknowledging and address handling. Storage is a simple dual-port RAM that an FPGA flow can map to block RAM.

The device select byte, MSB first, has these fields:
- bits 7:4 hold the device-type code 1010;
- bits 3:1 hold address bits 10:8;
- bit 0 is the direction (0 = write, 1 = read).

A write-direction transaction carries the low address byte next, then any data bytes. Data bytes collect in a 16-entry page buffer and are committed to the array when the transfer ends, either at STOP or at a repeated START. Reads are served from a single 11-bit address counter. The counter persists between transactions, so a read can name no address and carry on where the last access left off. A random read is a write-direction address phase, then a repeated START and a read-direction select byte.

Top module: `eei2c_eeprom`

## Requirements
- R1: The block ACKs a select byte only if bits 7:4 equal 1010. For any other value it leaves SDA released for the ACK bit and for the rest of that transfer, and its address counter is unchanged.
- R2: Byte write: the block ACKs the select byte, the address byte and one data byte. After STOP, the data byte is held at address {select bits 3:1, address byte}.
- R3: Page write: data bytes go to consecutive addresses, and only address bits 3:0 advance, so byte 17 onwards rolls over to the start of the same 16-byte page. A later byte overwrites an earlier byte at the same slot. Every data byte is ACKed.
- R4: Random read: a write-direction select byte plus address byte, then a repeated START and a read-direction select byte, returns the byte held at that address.
- R5: The counter holds the last accessed address plus one. After a write of n≥1 bytes starting at A, it is A with bits 3:0 advanced by n, modulo 16. A read that names no address starts at the counter, and in read direction select bits 3:1 are ignored.
- R6: During a read, every master ACK makes the block send the byte at the next address. The increment covers all 11 bits and wraps from 2047 to 0.
- R7: A master NACK after a data byte ends the read: the block keeps SDA released until the next START.
- R8: The block changes its SDA drive only while SCL is low. Data bits are sent and received MSB first.
- R9: Writes reach the array only when the transfer ends. An address-only write changes no stored byte but loads the counter. A STOP in the middle of a data byte discards the partial byte.
- R10: After reset, and at every STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume a well-formed bus:
- SCL low and high phases last several system clocks, longer than the synchronizer and edge-detector delay.
- The master changes SDA only while SCL is low, except when it means to signal START or STOP.
- No new transfer begins within 16 clocks of a STOP, so a pending page commit completes first.

The bench master holds each SCL phase for five or more clocks and places every SDA change one clock after SCL falls. It leaves an idle gap after each STOP, and its random transfers are built only from these legal bit-level tasks.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADR,
    ST_ADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } ctl_state_e;
endpackage

// File: rtl/eei2c_bus_cond.sv
module eei2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_d, sda_d;

  assign scl_s = scl_sr[SYNC_STAGES-1];
  assign sda_s = sda_sr[SYNC_STAGES-1];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr[g] <= 1'b1;
          sda_sr[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sr[g] <= scl_i;
          sda_sr[g] <= sda_i;
        end else begin
          scl_sr[g] <= scl_sr[(g == 0) ? 0 : g-1];
          sda_sr[g] <= sda_sr[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      scl_lvl   <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_d     <= scl_s;
      sda_d     <= sda_s;
      scl_lvl   <= scl_s;
      sda_lvl   <= sda_s;
      scl_rise  <= scl_s & ~scl_d;
      scl_fall  <= ~scl_s & scl_d;
      start_det <= scl_s & scl_d & sda_d & ~sda_s;
      stop_det  <= scl_s & scl_d & ~sda_d & sda_s;
    end
  end
endmodule

// File: rtl/eei2c_mem.sv
module eei2c_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/eei2c_ctrl.sv
module eei2c_ctrl
  import eei2c_pkg::*;
#(
  parameter int         AW       = 11,
  parameter int         PW       = 4,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam int HI_W  = AW - 8;
  localparam int PSIZE = 1 << PW;
  localparam int PB_W  = AW - PW;

  ctl_state_e         st;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg;
  logic               rw;
  logic               mack;
  logic [HI_W-1:0]    dev_hi;
  logic [AW-1:0]      cnt;
  logic [PB_W-1:0]    page_base;
  logic [PB_W-1:0]    commit_base;
  logic [7:0]         pbuf [PSIZE];
  logic [PSIZE-1:0]   bvalid;
  logic               commit_busy;
  logic [PW-1:0]      commit_idx;
  logic               bus_evt;
  logic               byte_end;

  assign rd_addr  = cnt;
  assign bus_evt  = start_det | stop_det;
  assign byte_end = scl_fall & (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      rw          <= 1'b0;
      mack        <= 1'b0;
      dev_hi      <= '0;
      cnt         <= '0;
      page_base   <= '0;
      commit_base <= '0;
      bvalid      <= '0;
      commit_busy <= 1'b0;
      commit_idx  <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      sda_oe      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (commit_busy) begin
        wr_en              <= bvalid[commit_idx];
        wr_addr            <= {commit_base, commit_idx};
        wr_data            <= pbuf[commit_idx];
        bvalid[commit_idx] <= 1'b0;
        commit_idx         <= commit_idx + 1'b1;
        if (&commit_idx) commit_busy <= 1'b0;
      end

      if (bus_evt) begin
        sda_oe <= 1'b0;
        bitcnt <= '0;
        st     <= start_det ? ST_DEV : ST_IDLE;
        if ((|bvalid) && !commit_busy) begin
          commit_busy <= 1'b1;
          commit_idx  <= '0;
          commit_base <= page_base;
        end
      end else begin
        unique case (st)
          ST_DEV, ST_ADR, ST_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_end) begin
              bitcnt <= '0;
              if (st == ST_DEV) begin
                if (shreg[7:4] == DEV_TYPE) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  if (!shreg[0]) dev_hi <= shreg[HI_W:1];
                  st     <= ST_DEV_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADR) begin
                cnt       <= {dev_hi, shreg};
                page_base <= {dev_hi, shreg[7:PW]};
                sda_oe    <= 1'b1;
                st        <= ST_ADR_ACK;
              end else begin
                pbuf[cnt[PW-1:0]]   <= shreg;
                bvalid[cnt[PW-1:0]] <= 1'b1;
                cnt[PW-1:0]         <= cnt[PW-1:0] + 1'b1;
                sda_oe              <= 1'b1;
                st                  <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_ADR;
              end
            end
          end
          ST_ADR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_end) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              cnt    <= cnt + 1'b1;
              st     <= ST_RACK;
            end else if (scl_fall) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(bus_evt)) |-> !scl_lvl);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDAT && byte_end && !bus_evt) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  page_roll_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDAT && byte_end && !bus_evt) |=>
      (cnt[AW-1:PW] == $past(cnt[AW-1:PW])) &&
      (cnt[PW-1:0] == $past(cnt[PW-1:0]) + 1'b1));

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK && scl_fall && !mack && !bus_evt) |=> (st == ST_IDLE && !sda_oe));

  // R9
  commit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(commit_busy));
endmodule

// File: rtl/eei2c_eeprom.sv
module eei2c_eeprom #(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 4,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]        rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;

  eei2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  eei2c_ctrl #(.AW(ADDR_W), .PW(PAGE_W), .DEV_TYPE(DEV_TYPE)) ctrl_i (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  eei2c_mem #(.AW(ADDR_W), .DW(8)) mem_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/eei2c_eeprom_tb_top.sv
`timescale 1ns/1ps
module eei2c_eeprom_tb_top;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  eei2c_eeprom dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  int r8_viol = 0;
  bit finished = 1'b0;
  logic prev_oe = 1'b0;

  logic [7:0]  ref_mem [0:2047];
  bit          known   [0:2047];
  logic [10:0] ref_cnt = '0;
  logic [7:0]  wbuf    [0:31];

  // R8 monitor: SDA drive may only move while SCL is low
  always @(negedge clk) begin
    prev_oe <= sda_oe;
    if (!rst && scl_m && (sda_oe != prev_oe)) r8_viol++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] page_slot(input logic [10:0] a, input int k);
    return {a[10:4], 4'(a[3:0] + k)};
  endfunction

  function automatic logic [7:0] sel_byte(input logic [2:0] hi, input bit rd);
    return {4'b1010, hi, rd};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(6 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      scl_m = 1'b0; wq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_bus;
    scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus;
      scl_m = 1'b0; wq(1);
    end
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(Q);
    scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [10:0] addr, input int n, input string tag);
    bit a;
    i2c_start();
    send_byte(sel_byte(addr[10:8], 1'b0), a);
    chk(a, "R1 select ack", a, 1);
    send_byte(addr[7:0], a);
    chk(a, "R2 address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      chk(a, tag, a, 1);
    end
    i2c_stop();
    for (int k = 0; k < n; k++) begin
      ref_mem[page_slot(addr, k)] = wbuf[k];
      known[page_slot(addr, k)]   = 1'b1;
    end
    ref_cnt = page_slot(addr, n);
  endtask

  task automatic rd_txn(input bit named, input logic [10:0] addr, input logic [2:0] hi_rd,
                        input int n, input string tag);
    bit a;
    logic [7:0] b;
    i2c_start();
    if (named) begin
      send_byte(sel_byte(addr[10:8], 1'b0), a);
      chk(a, "R4 select ack", a, 1);
      send_byte(addr[7:0], a);
      chk(a, "R4 address ack", a, 1);
      ref_cnt = addr;
      i2c_start();
    end
    send_byte(sel_byte(hi_rd, 1'b1), a);
    chk(a, "R1 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      if (known[ref_cnt]) chk(b === ref_mem[ref_cnt], (k == 0) ? tag : "R6 sequential data", b, ref_mem[ref_cnt]);
      ref_cnt = ref_cnt + 1'b1;
    end
    wq(Q);
    chk(sda_bus === 1'b1 && sda_oe === 1'b0, "R7 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    void'($urandom(32'd7321));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    wq(4);
    chk(sda_oe === 1'b0, "R10 reset release", sda_oe, 0);

    // R2 byte write then random read
    wbuf[0] = 8'h5c;
    wr_txn(11'h2a7, 1, "R2 data ack");
    rd_txn(1'b1, 11'h2a7, 3'd0, 1, "R4 random read");
    // R5 immediate read after write continues at +1; read-side hi bits ignored
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(11'h530, 2, "R3 data ack");
    rd_txn(1'b0, 11'h0, 3'd7, 1, "R5 immediate read");
    chk(ref_cnt == 11'h533, "R5 counter model", ref_cnt, 11'h533);

    // R3 page rollover: 18 bytes from offset 3
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h80 + k);
    wr_txn(11'h123, 18, "R3 data ack");
    rd_txn(1'b1, 11'h120, 3'd0, 16, "R3 page contents");
    chk(ref_mem[11'h123] == 8'h90 && ref_mem[11'h124] == 8'h91, "R3 overwrite model", ref_mem[11'h123], 8'h90);

    // R6 wrap from 2047 to 0
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(8'hc0 + k);
    wr_txn(11'h7f0, 16, "R3 data ack");
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(8'h40 + k);
    wr_txn(11'h000, 16, "R3 data ack");
    rd_txn(1'b1, 11'h7fe, 3'd0, 4, "R6 wrap read");
    rd_txn(1'b0, 11'h0, 3'd2, 1, "R6 counter after wrap");

    // R1 foreign device type: NACK, counter untouched
    i2c_start();
    send_byte(8'b1011_0000, a);
    chk(!a && sda_oe === 1'b0, "R1 foreign select NACK", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R1 silent after NACK", a, 0);
    i2c_stop();
    rd_txn(1'b0, 11'h0, 3'd0, 1, "R1 counter unchanged");

    // R9 address-only write: no store, counter loaded
    i2c_start();
    send_byte(sel_byte(3'd2, 1'b0), a);
    send_byte(8'ha7, a);
    chk(a, "R9 address ack", a, 1);
    i2c_stop();
    ref_cnt = 11'h2a7;
    rd_txn(1'b0, 11'h0, 3'd5, 1, "R9 address-only write");

    // R9 STOP in the middle of a data byte
    i2c_start();
    send_byte(sel_byte(3'd1, 1'b0), a);
    send_byte(8'h25, a);
    send_bits(8'h00, 4);
    i2c_stop();
    rd_txn(1'b1, 11'h125, 3'd0, 1, "R9 partial byte discarded");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int op, n;
      logic [10:0] ad;
      op = $urandom % 3;
      ad = 11'($urandom);
      if (op == 0) begin
        n = 1 + ($urandom % 18);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        wr_txn(ad, n, "R3 data ack");
      end else if (op == 1) begin
        rd_txn(1'b1, ad, 3'd0, 1 + ($urandom % 5), "R4 random read");
      end else begin
        rd_txn(1'b0, 11'h0, 3'($urandom), 1 + ($urandom % 4), "R5 immediate read");
      end
    end

    chk(r8_viol == 0, "R8 SDA moved while SCL high", r8_viol, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule